// File: doc/BRIEF.md
# GHASH Multiply-Accumulate Engine

This block runs the GHASH hashing step over a run of 128-bit element groups, each group being four 32-bit elements. For each group it fetches the running hash Y and a data block X through a group read port, adds them (bitwise XOR), and multiplies the sum by a hash subkey H in GF(2^128). The product is sent out through a group write port as the new hash for that group. H is sampled once, when the operation starts, and is shared by every group of the operation.

A mode flag selects multiply-only operation. In that mode the data block is treated as zero, so each group's hash is simply multiplied by H. The operation is launched by a one-cycle start pulse. The element count and the start element come with the pulse, together with a flag that marks the configuration as illegal. A one-cycle done pulse closes every operation, including one that is refused or that has no groups to process.

The multiplier handles one coefficient per clock. Every group therefore costs the same number of cycles, whatever its data. Group bytes sit on the bus with memory byte 0 in bits [7:0]. Inside each byte, polynomial coefficient 0 is the most significant bit.

Top module: `ghash_mac_engine`

## Requirements
- R1: Each written group equals r(P mod (x^128 + x^7 + x^2 + x + 1)), where P = r(Y xor X) times r(H) as polynomials over GF(2). Here r() reverses the bit order inside every byte of a 128-bit value, and bit i of r(v) is the coefficient of x^i.
- R2: With mul_only_i high at the start pulse, rd_x_i has no effect, and every result equals the add-multiply result with X = 0.
- R3: H is sampled only in the cycle of the accepted start pulse. Later changes on h_i do not alter any result of that operation.
- R4: Groups vstart/4 up to vl/4 - 1 are read and written once each, in ascending order, and wr_idx_o carries the group index.
- R5: Latency does not depend on the data. Counting the start-sampling edge as cycle 0, the k-th write (k from 0) is presented in cycle 130 + 130k. done_o is high for exactly one cycle, in cycle 130n + 1, where n is the number of groups.
- R6: If bad_cfg_i is high, or vl_i or vstart_i is not a multiple of 4, the engine makes no write and raises done_o in cycle 1.
- R7: If vstart_i >= vl_i, the engine makes no write and raises done_o in cycle 1.
- R8: A start pulse that arrives while busy_o is high is ignored.
- R9: During and straight after reset, busy_o, done_o, rd_en_o and wr_en_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| mul_only_i | input | 1 | 1 = multiply only (X treated as zero) |
| vl_i | input | IDX_W | Element count (end of the group range, in elements) |
| vstart_i | input | IDX_W | First element to process |
| bad_cfg_i | input | 1 | Configuration cannot hold a 128-bit group; refuse the operation |
| h_i | input | 128 | Hash subkey group (scalar source, group 0) |
| rd_en_o | output | 1 | Group read strobe |
| rd_idx_o | output | IDX_W-2 | Group index being read |
| rd_y_i | input | 128 | Running hash of the addressed group, same cycle |
| rd_x_i | input | 128 | Data block of the addressed group, same cycle |
| wr_en_o | output | 1 | Group write strobe |
| wr_idx_o | output | IDX_W-2 | Group index being written |
| wr_data_o | output | 128 | New hash value |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Each group spends one cycle on its read, 128 cycles multiplying and one cycle on its write. The first write is therefore due 130 cycles after the start is sampled, every later write follows 130 cycles after the one before, and done comes one cycle after the last write (cycle 1 when nothing is written). The bench counts clock edges from the sampling edge and looks at the outputs on the falling edge. Each write must land on its exact cycle with the expected index and data, and the done pulse must fall on its computed cycle. Refused and empty operations are held to cycle 1 the same way.

// File: rtl/ghash_pkg.sv
package ghash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_RUN   = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIN   = 3'd4
  } gh_state_e;

endpackage

// File: rtl/ghash_brev8.sv
module ghash_brev8 #(
  parameter int W = 128
) (
  input  logic [W-1:0] in_i,
  output logic [W-1:0] out_o
);
  localparam int NBYTES = W / 8;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    for (genvar j = 0; j < 8; j++) begin : g_bit
      assign out_o[8*b + j] = in_i[8*b + 7 - j];
    end
  end

endmodule

// File: rtl/ghash_serial_mul.sv
module ghash_serial_mul #(
  parameter int           W   = 128,
  parameter logic [W-1:0] RED = W'(8'h87)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_h_i,
  input  logic [W-1:0] h_i,
  input  logic         ld_op_i,
  input  logic [W-1:0] s_i,
  input  logic         step_i,
  output logic [W-1:0] prod_o,
  output logic [W-1:0] rem_o
);

  logic [W-1:0] hbase_q, hs_q, s_q, acc_q;
  logic [W-1:0] hbase_d, hs_d, s_d, acc_d;

  // next-state: one coefficient of the sum per step, constant work per step
  always_comb begin
    hbase_d = hbase_q;
    hs_d    = hs_q;
    s_d     = s_q;
    acc_d   = acc_q;
    if (ld_h_i) begin
      hbase_d = h_i;
    end
    if (ld_op_i) begin
      hs_d  = hbase_q;
      s_d   = s_i;
      acc_d = '0;
    end else if (step_i) begin
      acc_d = acc_q ^ (hs_q & {W{s_q[0]}});
      hs_d  = {hs_q[W-2:0], 1'b0} ^ (RED & {W{hs_q[W-1]}});
      s_d   = {1'b0, s_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbase_q <= '0;
      hs_q    <= '0;
      s_q     <= '0;
      acc_q   <= '0;
    end else begin
      hbase_q <= hbase_d;
      hs_q    <= hs_d;
      s_q     <= s_d;
      acc_q   <= acc_d;
    end
  end

  assign prod_o = acc_q;
  assign rem_o  = s_q;

  AST_HBASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !ld_h_i) |=> (hbase_q == $past(hbase_q))); // R3

endmodule

// File: rtl/ghash_ctrl.sv
module ghash_ctrl
  import ghash_pkg::*;
#(
  parameter int IDX_W     = 8,
  parameter int GRP_SHIFT = 2,
  parameter int STEPS     = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [IDX_W-1:0]       vl_i,
  input  logic [IDX_W-1:0]       vstart_i,
  input  logic                   bad_cfg_i,
  output logic                   ld_h_o,
  output logic                   ld_op_o,
  output logic                   step_o,
  output logic                   rd_en_o,
  output logic                   wr_en_o,
  output logic [IDX_W-GRP_SHIFT-1:0] grp_o,
  output logic                   busy_o,
  output logic                   done_o
);
  localparam int GI_W  = IDX_W - GRP_SHIFT;
  localparam int CNT_W = $clog2(STEPS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEPS - 1);

  gh_state_e         st_q, st_d;
  logic [GI_W-1:0]   grp_q, grp_d;
  logic [GI_W-1:0]   last_q, last_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              illegal, empty;
  logic [GI_W:0]     grp_inc;

  assign illegal = bad_cfg_i
                 || (vl_i[GRP_SHIFT-1:0] != '0)
                 || (vstart_i[GRP_SHIFT-1:0] != '0);
  assign empty   = (vstart_i >= vl_i);
  assign grp_inc = {1'b0, grp_q} + 1'b1;

  always_comb begin
    st_d    = st_q;
    grp_d   = grp_q;
    last_d  = last_q;
    cnt_d   = cnt_q;
    ld_h_o  = 1'b0;
    ld_op_o = 1'b0;
    step_o  = 1'b0;
    rd_en_o = 1'b0;
    wr_en_o = 1'b0;
    done_o  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          ld_h_o = 1'b1;
          grp_d  = vstart_i[IDX_W-1:GRP_SHIFT];
          last_d = vl_i[IDX_W-1:GRP_SHIFT];
          st_d   = (illegal || empty) ? ST_FIN : ST_LOAD;
        end
      end
      ST_LOAD: begin
        ld_op_o = 1'b1;
        rd_en_o = 1'b1;
        cnt_d   = '0;
        st_d    = ST_RUN;
      end
      ST_RUN: begin
        step_o = 1'b1;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST) st_d = ST_WRITE;
      end
      ST_WRITE: begin
        wr_en_o = 1'b1;
        grp_d   = grp_inc[GI_W-1:0];
        st_d    = (grp_inc == {1'b0, last_q}) ? ST_FIN : ST_LOAD;
      end
      ST_FIN: begin
        done_o = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      last_q <= '0;
      cnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      grp_q  <= grp_d;
      last_q <= last_d;
      cnt_q  <= cnt_d;
    end
  end

  assign grp_o  = grp_q;
  assign busy_o = (st_q != ST_IDLE);

  AST_WRITE_AFTER_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> ($past(step_o) && $past(cnt_q) == CNT_LAST)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (grp_q < last_q)); // R4
  AST_REFUSE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (illegal || empty)) |=> (done_o && !wr_en_o)); // R6
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o && !done_o) |=> $stable(last_q)); // R8

endmodule

// File: rtl/ghash_mac_engine.sv
module ghash_mac_engine #(
  parameter int             IDX_W    = 8,
  parameter int             GRP_W    = 128,
  parameter int             ELEM_W   = 32,
  parameter logic [127:0]   RED_POLY = 128'h87
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     mul_only_i,
  input  logic [IDX_W-1:0]         vl_i,
  input  logic [IDX_W-1:0]         vstart_i,
  input  logic                     bad_cfg_i,
  input  logic [GRP_W-1:0]         h_i,
  output logic                     rd_en_o,
  output logic [IDX_W-3:0]         rd_idx_o,
  input  logic [GRP_W-1:0]         rd_y_i,
  input  logic [GRP_W-1:0]         rd_x_i,
  output logic                     wr_en_o,
  output logic [IDX_W-3:0]         wr_idx_o,
  output logic [GRP_W-1:0]         wr_data_o,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int EGS       = GRP_W / ELEM_W;
  localparam int GRP_SHIFT = $clog2(EGS);
  localparam int GI_W      = IDX_W - GRP_SHIFT;

  logic              ld_h, ld_op, step;
  logic [GI_W-1:0]   grp;
  logic              mode_q, mode_d;
  logic [GRP_W-1:0]  x_eff, sum_raw, sum_rev, h_rev, prod, s_rem;

  ghash_ctrl #(
    .IDX_W     (IDX_W),
    .GRP_SHIFT (GRP_SHIFT),
    .STEPS     (GRP_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .vl_i      (vl_i),
    .vstart_i  (vstart_i),
    .bad_cfg_i (bad_cfg_i),
    .ld_h_o    (ld_h),
    .ld_op_o   (ld_op),
    .step_o    (step),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .grp_o     (grp),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  // mode flag register, enabled only by an accepted start
  always_comb begin
    mode_d = mode_q;
    if (ld_h) mode_d = mul_only_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= mode_d;
  end

  assign x_eff   = mode_q ? '0 : rd_x_i;
  assign sum_raw = rd_y_i ^ x_eff;

  ghash_brev8 #(.W(GRP_W)) u_rev_sum (.in_i(sum_raw), .out_o(sum_rev));
  ghash_brev8 #(.W(GRP_W)) u_rev_h   (.in_i(h_i),     .out_o(h_rev));
  ghash_brev8 #(.W(GRP_W)) u_rev_out (.in_i(prod),    .out_o(wr_data_o));

  ghash_serial_mul #(
    .W   (GRP_W),
    .RED (RED_POLY[GRP_W-1:0])
  ) u_mul (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_h_i  (ld_h),
    .h_i     (h_rev),
    .ld_op_i (ld_op),
    .s_i     (sum_rev),
    .step_i  (step),
    .prod_o  (prod),
    .rem_o   (s_rem)
  );

  assign rd_idx_o = grp;
  assign wr_idx_o = grp;

  AST_SUM_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (s_rem == '0)); // R5
  AST_IO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en_o && wr_en_o)); // R4
  AST_WR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> busy_o); // R9

endmodule

// File: tb/sim_ghash_mac_engine.sv
module sim_ghash_mac_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 100000;
  localparam int NVEC       = 6;

  // stimulus table: {y, x, h, mul_only}
  localparam logic [384:0] VEC [NVEC] = '{
    {128'h0, 128'h0, 128'h0123456789abcdef0011223344556677, 1'b0},
    {128'hffffffffffffffffffffffffffffffff, 128'h0,
     128'hffffffffffffffffffffffffffffffff, 1'b0},
    {128'h13579bdf2468ace0deadbeefcafef00d, 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0,
     128'h80000000000000000000000000000000, 1'b0},
    {128'h00000000000000000000000000000040, 128'h55555555aaaaaaaa55555555aaaaaaaa,
     128'hc2000000000000000000000000000001, 1'b1},
    {128'h8badf00d8badf00d8badf00d8badf00d, 128'h1234567890abcdef1234567890abcdef,
     128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0},
    {128'h00000000000000000000000000000001, 128'h00000000000000000000000000000002,
     128'h00000000000000000000000000000080, 1'b1}
  };

  logic         clk, rst_n;
  logic         start, mul_only, bad_cfg;
  logic [7:0]   vl, vstart;
  logic [127:0] h_drv;
  logic         rd_en, wr_en, busy, done;
  logic [5:0]   rd_idx, wr_idx;
  logic [127:0] rd_y, rd_x, wr_data;
  logic [127:0] ymem [64];
  logic [127:0] xmem [64];

  int nchk, nfail;

  assign rd_y = ymem[rd_idx];
  assign rd_x = xmem[rd_idx];

  ghash_mac_engine u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .mul_only_i (mul_only),
    .vl_i       (vl),
    .vstart_i   (vstart),
    .bad_cfg_i  (bad_cfg),
    .h_i        (h_drv),
    .rd_en_o    (rd_en),
    .rd_idx_o   (rd_idx),
    .rd_y_i     (rd_y),
    .rd_x_i     (rd_x),
    .wr_en_o    (wr_en),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .busy_o     (busy),
    .done_o     (done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [127:0] rb8(input logic [127:0] v);
    logic [127:0] r;
    for (int b = 0; b < 16; b++)
      for (int j = 0; j < 8; j++)
        r[8*b + j] = v[8*b + 7 - j];
    return r;
  endfunction

  function automatic logic [127:0] bswap(input logic [127:0] v);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[8*b +: 8] = v[8*(15-b) +: 8];
    return r;
  endfunction

  // full product then top-down reduction
  function automatic logic [127:0] gf_ref(input logic [127:0] y, x, h, input logic mo);
    logic [127:0] a, b;
    logic [255:0] p;
    a = rb8(mo ? y : (y ^ x));
    b = rb8(h);
    p = '0;
    for (int i = 0; i < 128; i++)
      if (a[i]) p = p ^ ({128'b0, b} << i);
    for (int k = 254; k >= 128; k--)
      if (p[k]) p = p ^ (256'h87 << (k - 128)) ^ (256'b1 << k);
    return rb8(p[127:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] vs, input logic [7:0] vlen,
                        input logic mo, input logic bad,
                        input bit glitch, input bit restart,
                        input string req, output logic [127:0] last);
    logic [127:0] hs;
    int n, k, cyc, g0;
    bit ill;
    ill  = bad || (vlen[1:0] != 2'b0) || (vs[1:0] != 2'b0);
    n    = (ill || vs >= vlen) ? 0 : (int'(vlen >> 2) - int'(vs >> 2));
    g0   = int'(vs >> 2);
    last = '0;
    @(negedge clk);
    hs = h_drv;
    start = 1'b1; mul_only = mo; vl = vlen; vstart = vs; bad_cfg = bad;
    k = 0; cyc = 0;
    forever begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (glitch && cyc == 5) h_drv = ~h_drv;
      if (restart && cyc == 10) begin start = 1'b1; mul_only = ~mo; end
      if (restart && cyc == 11) start = 1'b0;
      if (wr_en) begin
        chk(wr_idx == 6'(g0 + k), req, "write index", 128'(wr_idx), 128'(g0 + k));
        chk(cyc == 130 + 130*k, req, "write cycle", 128'(cyc), 128'(130 + 130*k));
        chk(wr_data == gf_ref(ymem[g0+k], xmem[g0+k], hs, mo), req, "write data",
            wr_data, gf_ref(ymem[g0+k], xmem[g0+k], hs, mo));
        last = wr_data;
        k++;
      end
      if (done || cyc > 20000) break;
    end
    chk(done && cyc == 130*n + 1, req, "done cycle", 128'(cyc), 128'(130*n + 1));
    chk(k == n, req, "write count", 128'(k), 128'(n));
    mul_only = 1'b0; bad_cfg = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [127:0] res;
    nchk = 0; nfail = 0;
    rst_n = 1'b0; start = 1'b0; mul_only = 1'b0; bad_cfg = 1'b0;
    vl = '0; vstart = '0; h_drv = '0;
    for (int i = 0; i < 64; i++) begin
      ymem[i] = {4{32'(i) * 32'h9e3779b9}};
      xmem[i] = {4{32'(i) ^ 32'h5a5a0f0f}};
    end

    // R9: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && !wr_en && !rd_en, "R9", "outputs in reset",
        128'({busy, done, wr_en, rd_en}), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_en && !rd_en, "R9", "outputs after reset",
        128'({busy, done, wr_en, rd_en}), 128'h0);

    // R1 R2 R5: table of single-group vectors
    for (int v = 0; v < NVEC; v++) begin
      ymem[0] = VEC[v][384:257];
      xmem[0] = VEC[v][256:129];
      h_drv   = VEC[v][128:1];
      run_op(8'd0, 8'd4, VEC[v][0], 1'b0, 1'b0, 1'b0, "R1", res);
    end

    // R1: known GHASH step, standard byte strings mapped to the bus
    ymem[0] = '0;
    xmem[0] = bswap(128'h0388dace60b6a392f328c2b971b2fe78);
    h_drv   = bswap(128'h66e94bd4ef8a2c3b884cfa59ca342b2e);
    run_op(8'd0, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0, "R1", res);
    chk(res == bswap(128'h5e2ec746917062882c85b0685353deb7), "R1", "known answer",
        res, bswap(128'h5e2ec746917062882c85b0685353deb7));

    // R1: x * x^127 = x^128 -> reduces to x^7+x^2+x+1
    ymem[0] = 128'h40; xmem[0] = '0;
    h_drv   = 128'h01 << 120;
    run_op(8'd0, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0, "R1", res);
    chk(res == 128'he1, "R1", "reduction", res, 128'he1);

    // R2: multiply-only ignores X
    ymem[0] = 128'h0f0f0f0f_00000000_12345678_9abcdef0;
    xmem[0] = 128'hffffffff_ffffffff_ffffffff_ffffffff;
    h_drv   = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    run_op(8'd0, 8'd4, 1'b1, 1'b0, 1'b0, 1'b0, "R2", res);
    chk(res == gf_ref(ymem[0], '0, h_drv, 1'b0), "R2", "equals X=0 result",
        res, gf_ref(ymem[0], '0, h_drv, 1'b0));

    // R3 R4 R8: groups 1..3, H toggled and extra start mid-run
    h_drv = 128'hc2000000000000000000000000000001;
    run_op(8'd4, 8'd16, 1'b0, 1'b0, 1'b1, 1'b1, "R3_R4_R8", res);

    // R4 R5: longer run from group 0
    run_op(8'd0, 8'd20, 1'b0, 1'b0, 1'b0, 1'b0, "R4", res);

    // R6: refused configurations
    run_op(8'd0, 8'd8, 1'b0, 1'b1, 1'b0, 1'b0, "R6", res);
    run_op(8'd0, 8'd6, 1'b0, 1'b0, 1'b0, 1'b0, "R6", res);
    run_op(8'd2, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0, "R6", res);

    // R7: empty ranges
    run_op(8'd8, 8'd8, 1'b0, 1'b0, 1'b0, 1'b0, "R7", res);
    run_op(8'd12, 8'd4, 1'b0, 1'b0, 1'b0, 1'b0, "R7", res);

    @(negedge clk);
    chk(!busy && !done, "R9", "idle at end", 128'({busy, done}), 128'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule